// File: doc/BRIEF.md
# Indirect Register Window Mailbox

This block lets a narrow host bus reach a bank of registers that lives in a DSP's address space, without mapping that bank onto the host bus. The host sees two ports: a command port and a data port. It writes a command byte that carries a direction bit and a register offset, then waits for a ready flag. The DSP side gets an interrupt request and sees the same two ports at fixed addresses of its own. DSP firmware carries out the transfer between the data port and the register window, then sets ready again.

For a write, the host loads the data port first and then issues the command. For a read, the host issues the command, waits for ready, and then takes the value from the data port. The register window is a 64-entry array on an aligned base in the DSP address map. A command that arrives while a transfer is still open is dropped, and a sticky overrun flag records the loss.

Top module: `regwin_mailbox`

## Requirements
- R1: After reset, h_ready is 1, d_irq is 0, h_overrun is 0, and both the command and data ports read 0.
- R2: A host write to the command port (h_sel=0) while h_ready is 1 stores the byte, with bit 7 as direction (1 = read, 0 = write) and bits 5:0 as the offset. The byte is readable on h_rdata with h_sel=0 and on d_rdata at DSP address 0x3040. h_ready is 0 from the next clock edge.
- R3: An accepted command sets d_irq at the next edge. d_irq stays at 1 until the DSP reads address 0x3040, and it is 0 after the edge that ends that read.
- R4: A host command write while h_ready is 0 leaves the stored command unchanged and sets h_overrun. h_overrun then stays at 1 until reset.
- R5: One data register backs both the host data port (h_sel=1) and DSP address 0x3041, and both sides read it back. If both sides write it in the same cycle, the DSP value is kept.
- R6: A DSP write to 0x3040 with d_wdata bit 0 = 1 sets h_ready to 1. With bit 0 = 0 it has no effect.
- R7: DSP addresses 0x2000 + offset, for offsets 0 to 63, read and write the window entries. A DSP address that is not mapped returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe |
| h_sel | input | 1 | Host port select: 0 = command, 1 = data |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data of the selected port |
| h_ready | output | 1 | Ready flag: no transfer is open |
| h_overrun | output | 1 | Sticky flag: a command was dropped |
| d_we | input | 1 | DSP write strobe |
| d_re | input | 1 | DSP read strobe |
| d_addr | input | 16 | DSP word address |
| d_wdata | input | 8 | DSP write data |
| d_rdata | output | 8 | DSP read data, 0 for unmapped addresses |
| d_irq | output | 1 | Register-access interrupt request to the DSP |

## Verification
A corrupted ready or interrupt state shows up one edge after the command that caused it. It appears as a ready flag that is still high, or as an interrupt that never rises or never falls after the command read. A wrong window decode or a lost data-port update is only seen once a later host read brings back the value. For that reason every random write is followed by a random read of a mixed offset, including offsets 0 and 63. A dropped-command fault becomes visible through the command byte that the host reads back while the transfer is still open.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CMD  = 2'd1,
    RGN_DATA = 2'd2,
    RGN_WIN  = 2'd3
  } dsp_rgn_e;
endpackage

// File: rtl/mb_ctrl.sv
// Command latch, ready flag, interrupt status and overrun flag.
module mb_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [CW-1:0] cmd_wdata,
  input  logic          dsp_cmd_rd,
  input  logic          dsp_rdy_set,
  output logic [CW-1:0] cmd_q,
  output logic          ready_q,
  output logic          irq_q,
  output logic          ovr_q
);
  logic          accept;
  logic [CW-1:0] cmd_d;
  logic          ready_d, irq_d, ovr_d;

  always_comb begin
    accept  = cmd_wr & ready_q;
    cmd_d   = accept ? cmd_wdata : cmd_q;
    ready_d = ready_q;
    if (accept)           ready_d = 1'b0;
    else if (dsp_rdy_set) ready_d = 1'b1;
    // A new command wins over a clearing read in the same cycle.
    irq_d   = accept | (irq_q & ~dsp_cmd_rd);
    ovr_d   = ovr_q | (cmd_wr & ~ready_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b1;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      ready_q <= ready_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
    end
  end
endmodule

// File: rtl/mb_dport.sv
// Shared data port; a DSP write wins over a host write in the same cycle.
module mb_dport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          dsp_wr,
  input  logic [DW-1:0] dsp_wdata,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] data_d;
  logic          data_en;

  always_comb begin
    data_en = host_wr | dsp_wr;
    data_d  = dsp_wr ? dsp_wdata : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end
endmodule

// File: rtl/mb_window.sv
// Register array standing in for the DSP-side window.
module mb_window #(
  parameter int DW    = 8,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFF_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic en;
    always_comb en = we && (addr == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (en) mem_q[i] <= wdata;
    end
  end

  always_comb rdata = mem_q[addr];
endmodule

// File: rtl/regwin_mailbox.sv
module regwin_mailbox
  import mb_pkg::*;
#(
  parameter int             DW        = 8,
  parameter int             OFF_W     = 6,
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  WIN_BASE  = 16'h2000,
  parameter logic [AW-1:0]  CMD_ADDR  = 16'h3040,
  parameter logic [AW-1:0]  DATA_ADDR = 16'h3041
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic          h_sel,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_ready,
  output logic          h_overrun,
  input  logic          d_we,
  input  logic          d_re,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  output logic [DW-1:0] d_rdata,
  output logic          d_irq
);
  // Command byte: direction bit, reserved bit, offset field.
  localparam int CW = OFF_W + 2;

  dsp_rgn_e      rgn;
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] win_rdata;

  always_comb begin
    if (d_addr == CMD_ADDR)                                   rgn = RGN_CMD;
    else if (d_addr == DATA_ADDR)                             rgn = RGN_DATA;
    else if (d_addr[AW-1:OFF_W] == WIN_BASE[AW-1:OFF_W])      rgn = RGN_WIN;
    else                                                      rgn = RGN_NONE;
  end

  mb_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (h_we && !h_sel),
    .cmd_wdata   (h_wdata[CW-1:0]),
    .dsp_cmd_rd  (d_re && (rgn == RGN_CMD)),
    .dsp_rdy_set (d_we && (rgn == RGN_CMD) && d_wdata[0]),
    .cmd_q       (cmd_q),
    .ready_q     (h_ready),
    .irq_q       (d_irq),
    .ovr_q       (h_overrun)
  );

  mb_dport #(.DW(DW)) u_dport (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (h_we && h_sel),
    .host_wdata (h_wdata),
    .dsp_wr     (d_we && (rgn == RGN_DATA)),
    .dsp_wdata  (d_wdata),
    .data_q     (data_q)
  );

  mb_window #(.DW(DW), .OFF_W(OFF_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (d_we && (rgn == RGN_WIN)),
    .addr  (d_addr[OFF_W-1:0]),
    .wdata (d_wdata),
    .rdata (win_rdata)
  );

  always_comb begin
    h_rdata = h_sel ? data_q : DW'(cmd_q);
    unique case (rgn)
      RGN_CMD:  d_rdata = DW'(cmd_q);
      RGN_DATA: d_rdata = data_q;
      RGN_WIN:  d_rdata = win_rdata;
      default:  d_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
  parameter int            DW       = 8,
  parameter int            AW       = 16,
  parameter int            CW       = 8,
  parameter logic [AW-1:0] CMD_ADDR = 16'h3040
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_we,
  input logic          h_sel,
  input logic          h_ready,
  input logic          h_overrun,
  input logic          d_we,
  input logic          d_re,
  input logic [AW-1:0] d_addr,
  input logic [DW-1:0] d_wdata,
  input logic          d_irq,
  input logic [CW-1:0] cmd_q
);
  logic acc, busy_wr, cmd_rd, rdy_set;
  always_comb begin
    acc     = h_we && !h_sel && h_ready;
    busy_wr = h_we && !h_sel && !h_ready;
    cmd_rd  = d_re && (d_addr == CMD_ADDR);
    rdy_set = d_we && (d_addr == CMD_ADDR) && d_wdata[0];
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !h_ready); // R2
  AST_ACCEPT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> d_irq); // R3
  AST_IRQ_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !acc) |=> !d_irq); // R3
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (d_irq && !cmd_rd) |=> d_irq); // R3
  AST_BUSY_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr |=> ($stable(cmd_q) && h_overrun)); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    h_overrun |=> h_overrun); // R4
  AST_READY_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_ready) |-> $past(rdy_set)); // R6
endmodule

bind regwin_mailbox mb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_we      (h_we),
  .h_sel     (h_sel),
  .h_ready   (h_ready),
  .h_overrun (h_overrun),
  .d_we      (d_we),
  .d_re      (d_re),
  .d_addr    (d_addr),
  .d_wdata   (d_wdata),
  .d_irq     (d_irq),
  .cmd_q     (cmd_q)
);

// File: tb/tb_regwin_mailbox.sv
`timescale 1ns/1ps
module tb_regwin_mailbox;
  logic        clk, rst_n;
  logic        h_we, h_sel;
  logic [7:0]  h_wdata, h_rdata;
  logic        h_ready, h_overrun;
  logic        d_we, d_re;
  logic [15:0] d_addr;
  logic [7:0]  d_wdata, d_rdata;
  logic        d_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] model [64];

  regwin_mailbox dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] win_addr(input logic [5:0] off);
    return 16'h2000 + 16'(off);
  endfunction

  function automatic logic [7:0] cmd_byte(input bit rd, input logic [5:0] off);
    return {rd, 1'b0, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input bit sel, input logic [7:0] v);
    @(negedge clk); h_we = 1'b1; h_sel = sel; h_wdata = v;
    @(posedge clk); #1 h_we = 1'b0;
  endtask

  task automatic host_rd(input bit sel, output logic [7:0] v);
    @(negedge clk); h_sel = sel; #1 v = h_rdata;
  endtask

  task automatic dsp_wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); d_we = 1'b1; d_addr = a; d_wdata = v;
    @(posedge clk); #1 d_we = 1'b0;
  endtask

  task automatic dsp_rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); d_re = 1'b1; d_addr = a; #1 v = d_rdata;
    @(posedge clk); #1 d_re = 1'b0;
  endtask

  // Firmware model: carries out the open command and sets ready.
  task automatic firmware(input logic [7:0] exp_cmd);
    logic [7:0] c, v;
    @(negedge clk);
    chk("R3 irq raised", d_irq, 1'b1);
    dsp_rd(16'h3040, c);
    chk("R2 dsp sees cmd", c, exp_cmd);
    @(negedge clk);
    chk("R3 irq cleared by read", d_irq, 1'b0);
    if (c[7]) begin
      dsp_rd(win_addr(c[5:0]), v);
      dsp_wr(16'h3041, v);
    end else begin
      dsp_rd(16'h3041, v);
      dsp_wr(win_addr(c[5:0]), v);
    end
    dsp_wr(16'h3040, 8'h01);
    @(negedge clk);
    chk("R6 ready set", h_ready, 1'b1);
  endtask

  task automatic do_write(input logic [5:0] off, input logic [7:0] v);
    host_wr(1'b1, v);
    host_wr(1'b0, cmd_byte(1'b0, off));
    @(negedge clk);
    chk("R2 ready cleared", h_ready, 1'b0);
    firmware(cmd_byte(1'b0, off));
    model[off] = v;
  endtask

  task automatic do_read(input logic [5:0] off);
    logic [7:0] v;
    host_wr(1'b0, cmd_byte(1'b1, off));
    @(negedge clk);
    chk("R2 ready cleared", h_ready, 1'b0);
    firmware(cmd_byte(1'b1, off));
    host_rd(1'b1, v);
    chk("R7 window read via host", v, model[off]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    h_we = 0; h_sel = 0; h_wdata = 0;
    d_we = 0; d_re = 0; d_addr = 0; d_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 ready", h_ready, 1'b1);
    chk("R1 irq", d_irq, 1'b0);
    chk("R1 overrun", h_overrun, 1'b0);
    host_rd(1'b0, v); chk("R1 cmd port", v, 8'h00);
    host_rd(1'b1, v); chk("R1 data port", v, 8'h00);

    // R7 boundary offsets
    do_write(6'd0, 8'hA5);
    do_write(6'd63, 8'h5A);
    do_read(6'd0);
    do_read(6'd63);

    // R7 unmapped address: ignored, reads zero
    dsp_wr(16'h2040, 8'hEE);
    dsp_rd(16'h2040, v); chk("R7 unmapped reads 0", v, 8'h00);
    dsp_rd(win_addr(6'd0), v); chk("R7 unmapped no effect", v, 8'hA5);
    dsp_rd(win_addr(6'd63), v); chk("R7 unmapped no effect", v, 8'h5A);

    // R5 simultaneous data writes: DSP wins
    @(negedge clk);
    h_we = 1; h_sel = 1; h_wdata = 8'h11;
    d_we = 1; d_addr = 16'h3041; d_wdata = 8'h22;
    @(posedge clk); #1 h_we = 0; d_we = 0;
    host_rd(1'b1, v); chk("R5 dsp wins", v, 8'h22);
    host_wr(1'b1, 8'h33);
    dsp_rd(16'h3041, v); chk("R5 dsp sees host data", v, 8'h33);

    // R4 and R6: busy command dropped; ready write with bit0=0 ignored
    host_wr(1'b0, cmd_byte(1'b1, 6'd5));
    host_wr(1'b0, cmd_byte(1'b0, 6'd9));
    host_rd(1'b0, v); chk("R4 cmd kept", v, cmd_byte(1'b1, 6'd5));
    chk("R4 overrun set", h_overrun, 1'b1);
    dsp_wr(16'h3040, 8'h00);
    @(negedge clk); chk("R6 bit0=0 no effect", h_ready, 1'b0);
    firmware(cmd_byte(1'b1, 6'd5));
    host_rd(1'b1, v); chk("R7 read offset 5", v, model[5]);
    chk("R4 overrun sticky", h_overrun, 1'b1);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [5:0] off;
      off = 6'($urandom);
      v2  = 8'($urandom);
      if ($urandom % 2) do_write(off, v2);
      else              do_read(off);
      do_read(6'($urandom));
    end
    chk("R4 overrun still set", h_overrun, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule